// File: doc/BRIEF.md
# Dual-Ring Host/Engine Mailbox

This block carries 32-bit words between a host processor and an embedded engine. It has two small word rings, one for each direction. Each side has a simple register port with a request, a write enable, a 2-bit word address, write data and registered read data. On each side, one address is a data window: a write to it appends a word to the outgoing ring, and a read from it takes the oldest word from the incoming ring. The other two addresses are status/control words. Each of these words shows the ring geometry as a constant depth and free-running 8-bit write and read pointers, so software can work out the fill level as `wp - rp` modulo 256.

The host word also holds the interrupt enable, the write-one-to-clear interrupt status, a doorbell strobe, a ready bit and a reset bit. The engine word has the matching enable, status, doorbell and ready bits, and it shows the host reset bit read-only. A doorbell or a ready change on one side raises the interrupt status on the other side. Bringing the link up follows this sequence: set reset, clear reset while ringing the doorbell, then set enable, doorbell and ready together.

Top module: `mbx_top`

## Requirements
- R1: Both status words share one layout: depth in [31:24], write pointer in [23:16], read pointer in [15:8], sticky overflow in [5], host reset in [4], ready in [3], doorbell in [2] (always reads 0), interrupt status in [1], interrupt enable in [0]. Bits [7:6] read 0. After reset both words read 0x08000000 when DEPTH is 8. Each side reads its own word at address 0, the other side's word at address 1, and its data window at address 2. The host word reports the host-to-engine ring, and the engine word reports the engine-to-host ring.
- R2: A write to address 2 appends the word to the outgoing ring and advances its write pointer. A read of address 2 returns the oldest word of the incoming ring and advances its read pointer, so order is kept in both directions.
- R3: A push into a full ring (fill equal to DEPTH) is dropped, leaves the write pointer unchanged and sets that ring's sticky overflow bit.
- R4: A pop from an empty ring returns 0 and leaves the read pointer unchanged.
- R5: Writing the host word with bit 1 set clears the host interrupt status, and writing it with bit 1 clear leaves the status unchanged. A set event in the same cycle wins over the clear.
- R6: The host interrupt status is set when the engine writes bit 2 = 1 or changes its ready bit. host_irq is high exactly when host enable and host status are both 1.
- R7: The engine interrupt status is set by a host doorbell (bit 2 = 1), by a change of the host ready bit, or by a rising host reset bit. It is cleared by an engine write with bit 1 = 1. eng_irq equals engine enable AND engine status.
- R8: While the host reset bit is set, host ready reads 0. Starting one cycle after reset is set, both rings hold zero pointers and clear overflow. Window pushes on either side are ignored and window pops return 0.
- R9: A host write with bit 4 set while the reset bit is already set is not a new reset event: it does not set the engine interrupt status.
- R10: Writing bit 4 = 0 with bit 2 = 1 releases reset and rings the engine. A following write of enable, doorbell and ready makes host ready read 1.
- R11: Ring pointers are free-running 8-bit values that wrap modulo 256, and order is kept across the wrap.
- R12: Read data appears on the rdata port the cycle after the read request and holds until the next read on that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 2 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Host interrupt |
| eng_req | input | 1 | Engine access strobe |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | 2 | Engine word address |
| eng_wdata | input | 32 | Engine write data |
| eng_rdata | output | 32 | Engine read data, registered |
| eng_irq | output | 1 | Engine interrupt |

## Verification
The bench fills the host ring one word past its depth. A design that wrapped its write pointer too early would overwrite the oldest word instead of dropping the newest, and the bench would see a wrong word or no overflow flag. It runs the pointers past 256 to catch an index that ignores the low bits or a fill count that is not taken modulo 256. It repeats the reset write while reset is held, which catches a level-triggered reset notice that would keep raising the engine interrupt. It also clears host status in the same cycle as an engine doorbell, which exposes a clear that is given priority over the set and would lose the notification.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BIT_IE  = 0;
    localparam int BIT_IS  = 1;
    localparam int BIT_DB  = 2;
    localparam int BIT_RDY = 3;
    localparam int BIT_RST = 4;

    typedef enum logic [1:0] {
        A_OWN  = 2'd0,
        A_PEER = 2'd1,
        A_WIN  = 2'd2,
        A_NONE = 2'd3
    } mbx_addr_e;

    typedef struct packed {
        logic [7:0] wp;
        logic [7:0] rp;
        logic       ovf;
    } ring_st_t;

    typedef struct packed {
        logic h_ie;
        logic h_is;
        logic h_rdy;
        logic h_rst;
        logic e_ie;
        logic e_is;
        logic e_rdy;
    } flags_t;

    typedef struct packed {
        logic [31:0] h;
        logic [31:0] e;
    } rdata_t;

endpackage

// File: rtl/mbx_ring.sv
module mbx_ring
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [7:0]    wr_ptr,
    output logic [7:0]    rd_ptr,
    output logic          ovf
);
    localparam int         AW     = $clog2(DEPTH);
    localparam logic [7:0] DEPTH8 = 8'(DEPTH);

    ring_st_t      st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [7:0]    fill;
    logic          full, empty, accept;

    always_comb begin
        st_d   = st_q;
        fill   = st_q.wp - st_q.rp;
        full   = (fill == DEPTH8);
        empty  = (fill == 8'd0);
        accept = push && !full && !clr;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) begin
                if (full) st_d.ovf = 1'b1;
                else      st_d.wp  = st_q.wp + 8'd1;
            end
            if (pop && !empty) st_d.rp = st_q.rp + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[st_q.wp[AW-1:0]] <= push_data;
    end

    assign pop_data = empty ? '0 : mem_q[st_q.rp[AW-1:0]];
    assign wr_ptr   = st_q.wp;
    assign rd_ptr   = st_q.rp;
    assign ovf      = st_q.ovf;

    // R3: fill never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH8);
    // R3: a push into a full ring is dropped and flagged
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> ($stable(st_q.wp) && st_q.ovf));
    // R4: a pop from an empty ring does not move the read pointer
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !clr) |=> $stable(st_q.rp));
    // R8: a clear empties the ring and drops the overflow flag
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.wp == 8'd0 && st_q.rp == 8'd0 && !st_q.ovf));

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_we,
    input  logic [4:0] h_bits,
    input  logic       e_we,
    input  logic [3:0] e_bits,
    output flags_t     flags
);
    flags_t st_d, st_q;
    logic   h_db, e_db, rst_rise;

    always_comb begin
        st_d     = st_q;
        h_db     = h_we && h_bits[BIT_DB];
        e_db     = e_we && e_bits[BIT_DB];
        rst_rise = h_we && h_bits[BIT_RST] && !st_q.h_rst;

        if (h_we) begin
            st_d.h_ie  = h_bits[BIT_IE];
            st_d.h_rst = h_bits[BIT_RST];
            st_d.h_rdy = h_bits[BIT_RDY];
            if (h_bits[BIT_IS]) st_d.h_is = 1'b0;
        end
        if (st_d.h_rst) st_d.h_rdy = 1'b0;

        if (e_we) begin
            st_d.e_ie  = e_bits[BIT_IE];
            st_d.e_rdy = e_bits[BIT_RDY];
            if (e_bits[BIT_IS]) st_d.e_is = 1'b0;
        end

        if (e_db || (st_d.e_rdy != st_q.e_rdy)) st_d.h_is = 1'b1;
        if (h_db || (st_d.h_rdy != st_q.h_rdy) || rst_rise) st_d.e_is = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q;

    // R5: write-one clears host status when nothing sets it
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_bits[BIT_IS] && !e_we) |=> !st_q.h_is);
    // R6: engine doorbell reaches the host
    p_db_to_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (e_we && e_bits[BIT_DB]) |=> st_q.h_is);
    // R7: host doorbell reaches the engine
    p_db_to_eng_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_bits[BIT_DB]) |=> st_q.e_is);
    // R9: repeated reset while held raises no new event
    p_rst_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_bits[BIT_RST] && st_q.h_rst && !h_bits[BIT_DB] && !st_q.e_is)
        |=> !st_q.e_is);

endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_irq,
    input  logic        eng_req,
    input  logic        eng_we,
    input  logic [1:0]  eng_addr,
    input  logic [31:0] eng_wdata,
    output logic [31:0] eng_rdata,
    output logic        eng_irq
);
    localparam logic [7:0] DEPTH8 = 8'(DEPTH);

    flags_t      fl;
    rdata_t      rd_d, rd_q;
    mbx_addr_e   h_a, e_a;
    logic        h_wr, h_rd, e_wr, e_rd;
    logic        h2e_push, h2e_pop, e2h_push, e2h_pop;
    logic [31:0] h2e_data, e2h_data;
    logic [7:0]  h2e_wp, h2e_rp, e2h_wp, e2h_rp;
    logic        h2e_ovf, e2h_ovf;
    logic [31:0] host_csr, eng_csr;

    assign h_a  = mbx_addr_e'(host_addr);
    assign e_a  = mbx_addr_e'(eng_addr);
    assign h_wr = host_req && host_we;
    assign h_rd = host_req && !host_we;
    assign e_wr = eng_req && eng_we;
    assign e_rd = eng_req && !eng_we;

    assign h2e_push = h_wr && (h_a == A_WIN) && !fl.h_rst;
    assign e2h_pop  = h_rd && (h_a == A_WIN) && !fl.h_rst;
    assign e2h_push = e_wr && (e_a == A_WIN) && !fl.h_rst;
    assign h2e_pop  = e_rd && (e_a == A_WIN) && !fl.h_rst;

    mbx_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .h_we   (h_wr && (h_a == A_OWN)),
        .h_bits (host_wdata[4:0]),
        .e_we   (e_wr && (e_a == A_OWN)),
        .e_bits (eng_wdata[3:0]),
        .flags  (fl)
    );

    mbx_ring #(.DEPTH(DEPTH), .DW(32)) u_h2e (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fl.h_rst),
        .push      (h2e_push),
        .push_data (host_wdata),
        .pop       (h2e_pop),
        .pop_data  (h2e_data),
        .wr_ptr    (h2e_wp),
        .rd_ptr    (h2e_rp),
        .ovf       (h2e_ovf)
    );

    mbx_ring #(.DEPTH(DEPTH), .DW(32)) u_e2h (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fl.h_rst),
        .push      (e2h_push),
        .push_data (eng_wdata),
        .pop       (e2h_pop),
        .pop_data  (e2h_data),
        .wr_ptr    (e2h_wp),
        .rd_ptr    (e2h_rp),
        .ovf       (e2h_ovf)
    );

    assign host_csr = {DEPTH8, h2e_wp, h2e_rp, 2'b00, h2e_ovf, fl.h_rst,
                       fl.h_rdy, 1'b0, fl.h_is, fl.h_ie};
    assign eng_csr  = {DEPTH8, e2h_wp, e2h_rp, 2'b00, e2h_ovf, fl.h_rst,
                       fl.e_rdy, 1'b0, fl.e_is, fl.e_ie};

    always_comb begin
        rd_d = rd_q;
        if (h_rd) begin
            case (h_a)
                A_OWN:   rd_d.h = host_csr;
                A_PEER:  rd_d.h = eng_csr;
                A_WIN:   rd_d.h = fl.h_rst ? 32'd0 : e2h_data;
                default: rd_d.h = 32'd0;
            endcase
        end
        if (e_rd) begin
            case (e_a)
                A_OWN:   rd_d.e = eng_csr;
                A_PEER:  rd_d.e = host_csr;
                A_WIN:   rd_d.e = fl.h_rst ? 32'd0 : h2e_data;
                default: rd_d.e = 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign host_rdata = rd_q.h;
    assign eng_rdata  = rd_q.e;
    assign host_irq   = fl.h_ie && fl.h_is;
    assign eng_irq    = fl.e_ie && fl.e_is;

endmodule

// File: tb/mbx_top_tb.sv
module mbx_top_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        host_irq;
    logic        eng_req = 1'b0, eng_we = 1'b0;
    logic [1:0]  eng_addr = 2'd0;
    logic [31:0] eng_wdata = 32'd0;
    logic [31:0] eng_rdata;
    logic        eng_irq;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mbx_top #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_irq(eng_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_h2e[$];
    logic [31:0] m_e2h[$];
    int  m_hwp, m_hrp, m_ewp, m_erp;
    bit  m_hovf, m_eovf, m_hie, m_his, m_hrdy, m_hrst, m_eie, m_eis, m_erdy;
    logic [31:0] m_hrd, m_erd;

    function automatic logic [31:0] word(int wp, int rp, bit ov, bit rs, bit rdy, bit is, bit ie);
        return {8'(DEPTH), 8'(wp), 8'(rp), 2'b00, ov, rs, rdy, 1'b0, is, ie};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_h2e.delete(); m_e2h.delete();
            m_hwp = 0; m_hrp = 0; m_ewp = 0; m_erp = 0;
            {m_hovf, m_eovf, m_hie, m_his, m_hrdy, m_hrst, m_eie, m_eis, m_erdy} = '0;
            m_hrd = 0; m_erd = 0;
        end else begin
            bit hcw, ecw, nhie, nhis, nhrdy, nhrst, neie, neis, nerdy;
            logic [31:0] hw, ew;
            hw = host_wdata; ew = eng_wdata;
            hcw = host_req && host_we && host_addr == 2'd0;
            ecw = eng_req && eng_we && eng_addr == 2'd0;
            if (host_req && !host_we)
                case (host_addr)
                    2'd0: m_hrd = word(m_hwp, m_hrp, m_hovf, m_hrst, m_hrdy, m_his, m_hie);
                    2'd1: m_hrd = word(m_ewp, m_erp, m_eovf, m_hrst, m_erdy, m_eis, m_eie);
                    2'd2: m_hrd = (m_hrst || m_e2h.size() == 0) ? 32'd0 : m_e2h[0];
                    default: m_hrd = 0;
                endcase
            if (eng_req && !eng_we)
                case (eng_addr)
                    2'd0: m_erd = word(m_ewp, m_erp, m_eovf, m_hrst, m_erdy, m_eis, m_eie);
                    2'd1: m_erd = word(m_hwp, m_hrp, m_hovf, m_hrst, m_hrdy, m_his, m_hie);
                    2'd2: m_erd = (m_hrst || m_h2e.size() == 0) ? 32'd0 : m_h2e[0];
                    default: m_erd = 0;
                endcase
            if (m_hrst) begin
                m_h2e.delete(); m_e2h.delete();
                m_hwp = 0; m_hrp = 0; m_ewp = 0; m_erp = 0; m_hovf = 0; m_eovf = 0;
            end else begin
                if (host_req && host_addr == 2'd2) begin
                    if (host_we) begin
                        if (m_h2e.size() == DEPTH) m_hovf = 1;
                        else begin m_h2e.push_back(hw); m_hwp = (m_hwp + 1) % 256; end
                    end else if (m_e2h.size() > 0) begin
                        void'(m_e2h.pop_front()); m_erp = (m_erp + 1) % 256;
                    end
                end
                if (eng_req && eng_addr == 2'd2) begin
                    if (eng_we) begin
                        if (m_e2h.size() == DEPTH) m_eovf = 1;
                        else begin m_e2h.push_back(ew); m_ewp = (m_ewp + 1) % 256; end
                    end else if (m_h2e.size() > 0) begin
                        void'(m_h2e.pop_front()); m_hrp = (m_hrp + 1) % 256;
                    end
                end
            end
            nhie = m_hie; nhis = m_his; nhrdy = m_hrdy; nhrst = m_hrst;
            neie = m_eie; neis = m_eis; nerdy = m_erdy;
            if (hcw) begin
                nhie = hw[0]; nhrst = hw[4]; nhrdy = hw[3];
                if (hw[1]) nhis = 0;
            end
            if (nhrst) nhrdy = 0;
            if (ecw) begin
                neie = ew[0]; nerdy = ew[3];
                if (ew[1]) neis = 0;
            end
            if ((ecw && ew[2]) || nerdy != m_erdy) nhis = 1;
            if ((hcw && hw[2]) || nhrdy != m_hrdy || (hcw && hw[4] && !m_hrst)) neis = 1;
            m_hie = nhie; m_his = nhis; m_hrdy = nhrdy; m_hrst = nhrst;
            m_eie = neie; m_eis = neis; m_erdy = nerdy;
        end
    end

    // every-clock comparison against the model (R12 read data timing, R6/R7 irqs)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 host_rdata vs model", host_rdata, m_hrd);
            chk("R12 eng_rdata vs model", eng_rdata, m_erd);
            chk("R6 host_irq vs model", 32'(host_irq), 32'(m_hie && m_his));
            chk("R7 eng_irq vs model", 32'(eng_irq), 32'(m_eie && m_eis));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic hop(input bit we, input logic [1:0] a, input logic [31:0] d);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic eop(input bit we, input logic [1:0] a, input logic [31:0] d);
        eng_req = 1'b1; eng_we = we; eng_addr = a; eng_wdata = d;
        @(negedge clk);
        eng_req = 1'b0; eng_we = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        hop(1'b0, a, 32'd0);
        chk(tag, host_rdata, exp);
    endtask

    task automatic erd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        eop(1'b0, a, 32'd0);
        chk(tag, eng_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 host_irq at reset", 32'(host_irq), 32'd0);
        hrd(2'd0, 32'h0800_0000, "R1 host word at reset");
        erd(2'd0, 32'h0800_0000, "R1 engine word at reset");

        // R10 / R7 / R6 bring-up
        hop(1'b1, 2'd0, 32'h04);
        erd(2'd0, 32'h0800_0002, "R7 host doorbell sets engine status");
        eop(1'b1, 2'd0, 32'h02);
        erd(2'd0, 32'h0800_0000, "R7 engine status write-one-clear");
        eop(1'b1, 2'd0, 32'h08);
        hop(1'b1, 2'd0, 32'h0D);
        chk("R6 ready change raises host irq", 32'(host_irq), 32'd1);
        hrd(2'd0, 32'h0800_000B, "R10 host ready after bring-up");
        hop(1'b1, 2'd0, 32'h0B);
        chk("R5 write-one clears host irq", 32'(host_irq), 32'd0);
        hrd(2'd0, 32'h0800_0009, "R5 status cleared");

        // R2 host to engine order
        hop(1'b1, 2'd2, 32'hA0A0_0001);
        hop(1'b1, 2'd2, 32'hB0B0_0002);
        hop(1'b1, 2'd2, 32'hC0C0_0003);
        hrd(2'd0, 32'h0803_0009, "R2 write pointer advanced");
        erd(2'd2, 32'hA0A0_0001, "R2 first word");
        erd(2'd2, 32'hB0B0_0002, "R2 second word");
        erd(2'd2, 32'hC0C0_0003, "R2 third word");
        erd(2'd1, 32'h0803_0309, "R2 read pointer advanced");

        // R4 empty pop
        erd(2'd2, 32'd0, "R4 pop from empty returns zero");
        erd(2'd1, 32'h0803_0309, "R4 read pointer unchanged");

        // R3 overflow
        for (int i = 0; i < 9; i++) hop(1'b1, 2'd2, 32'h100 + i);
        hrd(2'd0, 32'h080B_0329, "R3 dropped push sets overflow");
        for (int i = 0; i < 8; i++) erd(2'd2, 32'h100 + i, "R3 stored words intact");
        erd(2'd2, 32'd0, "R3 dropped word absent");

        // R6 engine doorbell
        eop(1'b1, 2'd0, 32'h0C);
        chk("R6 engine doorbell raises host irq", 32'(host_irq), 32'd1);
        hop(1'b1, 2'd0, 32'h0B);
        chk("R5 cleared again", 32'(host_irq), 32'd0);

        // R2 engine to host
        eop(1'b1, 2'd2, 32'h1234_5678);
        eop(1'b1, 2'd2, 32'h9ABC_DEF0);
        hrd(2'd2, 32'h1234_5678, "R2 engine word one");
        hrd(2'd2, 32'h9ABC_DEF0, "R2 engine word two");

        // R11 pointer wrap
        for (int i = 0; i < 250; i++) begin
            hop(1'b1, 2'd2, 32'h5000 + i);
            erd(2'd2, 32'h5000 + i, "R11 order across wrap");
        end
        erd(2'd1, 32'h0805_0529, "R11 pointers wrapped modulo 256");

        // R8 reset holds the rings empty
        hop(1'b1, 2'd2, 32'h77);
        hop(1'b1, 2'd2, 32'h88);
        hop(1'b1, 2'd0, 32'h19);
        idle(1);
        hrd(2'd0, 32'h0800_0011, "R8 reset clears pointers and ready");
        hop(1'b1, 2'd2, 32'hDEAD);
        idle(1);
        hrd(2'd0, 32'h0800_0011, "R8 push ignored during reset");
        erd(2'd2, 32'd0, "R8 pop returns zero during reset");

        // R9 repeated reset request
        eop(1'b1, 2'd0, 32'h0A);
        erd(2'd0, 32'h0800_0018, "R9 engine status cleared");
        hop(1'b1, 2'd0, 32'h10);
        erd(2'd0, 32'h0800_0018, "R9 repeated reset raises nothing");

        // R10 release and ready
        hop(1'b1, 2'd0, 32'h04);
        hrd(2'd0, 32'h0800_0000, "R10 reset released");
        erd(2'd0, 32'h0800_000A, "R10 release rings engine");
        hop(1'b1, 2'd0, 32'h0D);
        hrd(2'd0, 32'h0800_0009, "R10 host ready set");

        // R7 engine irq, R12 hold
        eop(1'b1, 2'd0, 32'h0B);
        chk("R7 engine irq low after clear", 32'(eng_irq), 32'd0);
        hop(1'b1, 2'd0, 32'h0D);
        chk("R7 host doorbell raises engine irq", 32'(eng_irq), 32'd1);
        hrd(2'd0, 32'h0800_0009, "R12 read value");
        idle(3);
        chk("R12 read data holds", host_rdata, 32'h0800_0009);

        // R5 set wins over clear in the same cycle; writing zero keeps status
        host_req = 1'b1; host_we = 1'b1; host_addr = 2'd0; host_wdata = 32'h0B;
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = 2'd0; eng_wdata = 32'h0D;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; eng_req = 1'b0; eng_we = 1'b0;
        chk("R5 set wins over clear", 32'(host_irq), 32'd1);
        hop(1'b1, 2'd0, 32'h09);
        chk("R5 writing zero keeps status", 32'(host_irq), 32'd1);
        hop(1'b1, 2'd0, 32'h0B);
        chk("R5 final clear", 32'(host_irq), 32'd0);

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule